// File: doc/BRIEF.md
# Inverter Leg Gate Interlock

This block sits between a pulse-width controller and the gate drivers of one inverter leg. It takes two active-high switch commands, one for the upper switch and one for the lower switch. From them it produces two registered gate-enable outputs. The two outputs are never high together. A leg whose commands conflict is left floating with both switches off. Every turn-on waits for a programmable gap after the opposite switch has turned off.

Two inputs override the commands. One is an active-low halt level. The other is an active-high fault-force line from a protection comparator. Either one clears both gates on the next clock edge and restarts the gap timer. Recovery therefore always begins with a full gap.

The behaviour is held by a six-state machine:

| State | Meaning |
|---|---|
| HALT | Forced off. The reset state. |
| IDLE | Off, with the gap served. |
| GAP_AFTER_HI | Off, counting after the upper gate fell. |
| GAP_AFTER_LO | Off, counting after the lower gate fell. |
| DRIVE_HI | Upper gate on. |
| DRIVE_LO | Lower gate on. |

The transitions are as follows:

- **Kill.** A halt or fault in any state goes to HALT.
- **Release.** HALT goes to IDLE, DRIVE_HI or DRIVE_LO once DEAD_CYC clean edges have been counted.
- **Start.** IDLE goes to DRIVE_HI or DRIVE_LO on a one-sided command.
- **Drop.** DRIVE_HI goes to GAP_AFTER_HI, and DRIVE_LO goes to GAP_AFTER_LO, when its one-sided command goes away.
- **Resume.** GAP_AFTER_HI goes back to DRIVE_HI on an upper command, and likewise for the lower side. The same side may resume at once.
- **Serve.** GAP_AFTER_x goes to the opposite DRIVE state, or to IDLE, when the count ends.

Top module: `leg_gate_guard`

## Requirements
- R1: During reset and after it, both gates are low. The first turn-on is made no earlier than the DEAD_CYC-th clock edge after reset is released.
- R2: A low on halt_n makes both gates low from the next clock edge on, whatever the commands are.
- R3: A high on fault_force makes both gates low from the next clock edge on, whatever the commands are.
- R4: With no override active and both commands high, both gates are low after the next edge.
- R5: With no override active and both commands low, both gates are low after the next edge.
- R6: A gate only turns on while its own command is high, the other command is low and no override is active. The upper command alone drives only hi_gate, and the lower command alone drives only lo_gate.
- R7: hi_gate and lo_gate are never high in the same cycle.
- R8: After one gate falls on edge E0, the other gate cannot rise before edge E0+DEAD_CYC. A request for it that arrives earlier is held until then, so both gates stay low for exactly DEAD_CYC cycles.
- R9: When the command of an active gate goes low, or the other command goes high, that gate falls on the next edge.
- R10: After halt or fault is released, a held one-sided command turns its gate on at the DEAD_CYC-th edge that samples both overrides inactive.
- R11: A gate whose opposite side has been low for at least DEAD_CYC cycles turns on at the first edge that samples its one-sided command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | Upper-switch command, active high |
| lo_cmd | input | 1 | Lower-switch command, active high |
| halt_n | input | 1 | Active-low halt for the whole leg |
| fault_force | input | 1 | Active-high forced-off request from protection |
| hi_gate | output | 1 | Upper gate enable, registered |
| lo_gate | output | 1 | Lower gate enable, registered |

## Verification
A directed sequence uses a gap of four cycles. It drives a side change to separate a held-off request from an immediate one. It resumes the same side to show that no gap is spent when the opposite switch never conducted. It also releases from halt and from fault to show that the counter restarts.

A sweep then holds each of the sixteen input combinations for one to six cycles. After that, a long pseudo-random run mixes short commands with rare overrides. Every cycle is compared with a cycle model written from the requirements. The hold lengths on both sides of the gap are what expose an off-by-one in the count.

// File: rtl/leg_guard_pkg.sv
package leg_guard_pkg;

    typedef enum logic [2:0] {
        GS_HALT         = 3'd0,
        GS_IDLE         = 3'd1,
        GS_GAP_AFTER_HI = 3'd2,
        GS_GAP_AFTER_LO = 3'd3,
        GS_DRIVE_HI     = 3'd4,
        GS_DRIVE_LO     = 3'd5
    } guard_state_t;

endpackage

// File: rtl/leg_cmd_qualify.sv
module leg_cmd_qualify (
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic halt_n,
    input  logic fault_force,
    output logic req_hi,
    output logic req_lo,
    output logic kill
);

    // An override wins over every command.
    always_comb begin
        kill   = !halt_n || fault_force;
        req_hi = hi_cmd && !lo_cmd;
        req_lo = lo_cmd && !hi_cmd;
    end

endmodule

// File: rtl/leg_gap_timer.sv
module leg_gap_timer #(
    parameter int DEAD_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);

    localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/leg_guard_fsm.sv
module leg_guard_fsm
    import leg_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    input  logic kill,
    input  logic gap_done,
    output logic tmr_clr,
    output logic tmr_run,
    output logic hi_gate,
    output logic lo_gate
);

    guard_state_t st, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= GS_HALT;
        end else begin
            st <= nxt;
        end
    end

    // Next state and timer control
    always_comb begin
        nxt     = st;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        if (kill) begin
            nxt     = GS_HALT;
            tmr_clr = 1'b1;
        end else begin
            unique case (st)
                GS_HALT: begin
                    if (gap_done) begin
                        nxt = req_hi ? GS_DRIVE_HI : (req_lo ? GS_DRIVE_LO : GS_IDLE);
                    end else begin
                        tmr_run = 1'b1;
                    end
                end
                GS_IDLE: begin
                    if (req_hi) begin
                        nxt = GS_DRIVE_HI;
                    end else if (req_lo) begin
                        nxt = GS_DRIVE_LO;
                    end
                end
                GS_GAP_AFTER_HI: begin
                    if (req_hi) begin
                        nxt = GS_DRIVE_HI;
                    end else if (gap_done) begin
                        nxt = req_lo ? GS_DRIVE_LO : GS_IDLE;
                    end else begin
                        tmr_run = 1'b1;
                    end
                end
                GS_GAP_AFTER_LO: begin
                    if (req_lo) begin
                        nxt = GS_DRIVE_LO;
                    end else if (gap_done) begin
                        nxt = req_hi ? GS_DRIVE_HI : GS_IDLE;
                    end else begin
                        tmr_run = 1'b1;
                    end
                end
                GS_DRIVE_HI: begin
                    if (!req_hi) begin
                        nxt     = GS_GAP_AFTER_HI;
                        tmr_clr = 1'b1;
                    end
                end
                GS_DRIVE_LO: begin
                    if (!req_lo) begin
                        nxt     = GS_GAP_AFTER_LO;
                        tmr_clr = 1'b1;
                    end
                end
                default: begin
                    nxt     = GS_HALT;
                    tmr_clr = 1'b1;
                end
            endcase
        end
    end

    // Outputs decoded from the state register only
    always_comb begin
        hi_gate = (st == GS_DRIVE_HI);
        lo_gate = (st == GS_DRIVE_LO);
    end

endmodule

// File: rtl/leg_gate_guard.sv
module leg_gate_guard #(
    parameter int DEAD_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic halt_n,
    input  logic fault_force,
    output logic hi_gate,
    output logic lo_gate
);

    logic req_hi, req_lo, kill;
    logic tmr_clr, tmr_run, gap_done;

    leg_cmd_qualify u_qual (
        .hi_cmd      (hi_cmd),
        .lo_cmd      (lo_cmd),
        .halt_n      (halt_n),
        .fault_force (fault_force),
        .req_hi      (req_hi),
        .req_lo      (req_lo),
        .kill        (kill)
    );

    leg_gap_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .done  (gap_done)
    );

    leg_guard_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_hi   (req_hi),
        .req_lo   (req_lo),
        .kill     (kill),
        .gap_done (gap_done),
        .tmr_clr  (tmr_clr),
        .tmr_run  (tmr_run),
        .hi_gate  (hi_gate),
        .lo_gate  (lo_gate)
    );

endmodule

// File: rtl/leg_gate_guard_chk.sv
module leg_gate_guard_chk #(
    parameter int DEAD_CYC = 18
) (
    input logic clk,
    input logic rst_n,
    input logic hi_cmd,
    input logic lo_cmd,
    input logic halt_n,
    input logic fault_force,
    input logic hi_gate,
    input logic lo_gate
);

    localparam int RW = $clog2(DEAD_CYC + 1);
    localparam logic [RW-1:0] FULL = RW'(DEAD_CYC);

    logic [RW-1:0] hi_off_run, lo_off_run, clean_run;

    // Saturating cycle counters that watch the ports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_off_run <= '0;
            lo_off_run <= '0;
            clean_run  <= '0;
        end else begin
            if (hi_gate) hi_off_run <= '0;
            else if (hi_off_run != FULL) hi_off_run <= hi_off_run + 1'b1;
            if (lo_gate) lo_off_run <= '0;
            else if (lo_off_run != FULL) lo_off_run <= lo_off_run + 1'b1;
            if (!halt_n || fault_force) clean_run <= '0;
            else if (clean_run != FULL) clean_run <= clean_run + 1'b1;
        end
    end

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));
    assert_halt_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |=> (!hi_gate && !lo_gate));
    assert_fault_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_force |=> (!hi_gate && !lo_gate));
    assert_both_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cmd && lo_cmd) |=> (!hi_gate && !lo_gate));
    assert_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_cmd && !lo_cmd) |=> (!hi_gate && !lo_gate));
    assert_hi_rise_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> $past(hi_cmd && !lo_cmd && halt_n && !fault_force));
    assert_lo_rise_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> $past(lo_cmd && !hi_cmd && halt_n && !fault_force));
    assert_hi_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> (lo_off_run >= FULL));
    assert_lo_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> (hi_off_run >= FULL));
    assert_hi_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gate && (!hi_cmd || lo_cmd)) |=> !hi_gate);
    assert_lo_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_gate && (!lo_cmd || hi_cmd)) |=> !lo_gate);
    assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_gate) || $rose(lo_gate)) |-> (clean_run >= FULL));

endmodule

bind leg_gate_guard leg_gate_guard_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_cmd      (hi_cmd),
    .lo_cmd      (lo_cmd),
    .halt_n      (halt_n),
    .fault_force (fault_force),
    .hi_gate     (hi_gate),
    .lo_gate     (lo_gate)
);

// File: tb/leg_gate_guard_tb.sv
module leg_gate_guard_tb;

    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, halt_n = 1'b1, fault_force = 1'b0;
    logic hi_gate, lo_gate;

    int checks = 0;
    int failures = 0;
    logic done_flag = 1'b0;

    // Cycle model written from the requirements
    logic m_hi, m_lo;
    int m_c, m_ghi, m_glo;

    always #4 clk = ~clk;

    leg_gate_guard #(.DEAD_CYC(D)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_cmd      (hi_cmd),
        .lo_cmd      (lo_cmd),
        .halt_n      (halt_n),
        .fault_force (fault_force),
        .hi_gate     (hi_gate),
        .lo_gate     (lo_gate)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi = 1'b0;
            m_lo = 1'b0;
            m_c = 0;
            m_ghi = D;
            m_glo = D;
        end else begin
            logic kl, rh, rl, nh, nl;
            kl = !halt_n || fault_force;
            if (m_hi) m_ghi = 0; else if (m_ghi < D) m_ghi = m_ghi + 1;
            if (m_lo) m_glo = 0; else if (m_glo < D) m_glo = m_glo + 1;
            if (kl) m_c = 0; else if (m_c < D) m_c = m_c + 1;
            rh = hi_cmd && !lo_cmd;
            rl = lo_cmd && !hi_cmd;
            nh = !kl && rh && (m_c >= D) && (m_glo >= D);
            nl = !kl && rl && (m_c >= D) && (m_ghi >= D);
            m_hi = nh;
            m_lo = nl;
        end
    end

    task automatic check(input string tag, input logic eh, input logic el);
        checks++;
        if (hi_gate !== eh || lo_gate !== el) begin
            failures++;
            $display("FAIL %s hi_gate=%b lo_gate=%b expected hi_gate=%b lo_gate=%b",
                     tag, hi_gate, lo_gate, eh, el);
        end
    endtask

    task automatic tick(input logic h, input logic l, input logic hn, input logic f);
        hi_cmd = h;
        lo_cmd = l;
        halt_n = hn;
        fault_force = f;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic h, input logic l,
                                     input logic hn, input logic f);
        if (!hn) return "R2";
        if (f) return "R3";
        if (h && l) return "R4";
        if (!h && !l) return "R5";
        return "R6/R8/R10/R11";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1: first turn-on at the D-th edge after release
        for (int i = 1; i < D; i++) begin
            tick(1, 0, 1, 0);
            check("R1 held after reset", 1'b0, 1'b0);
        end
        tick(1, 0, 1, 0);
        check("R1/R6 first turn-on", 1'b1, 1'b0);
        // R9 falling command, R5 no command
        tick(0, 0, 1, 0);
        check("R9/R5 drop", 1'b0, 0);
        // R11 same side again without a gap
        tick(1, 0, 1, 0);
        check("R11 resume", 1'b1, 1'b0);
        // R8 side change
        tick(0, 1, 1, 0);
        check("R9 hi falls on side change", 1'b0, 1'b0);
        for (int i = 1; i < D; i++) begin
            tick(0, 1, 1, 0);
            check("R8 request held off", 1'b0, 1'b0);
        end
        tick(0, 1, 1, 0);
        check("R8 lo after gap", 1'b0, 1'b1);
        // R4 interlock
        tick(1, 1, 1, 0);
        check("R4 both commands", 1'b0, 1'b0);
        tick(1, 1, 1, 0);
        check("R4 both commands held", 1'b0, 1'b0);
        tick(0, 1, 1, 0);
        check("R11 lo resumes", 1'b0, 1'b1);
        // R2 halt then R10 recovery
        tick(0, 1, 0, 0);
        check("R2 halt", 1'b0, 1'b0);
        tick(1, 0, 0, 0);
        check("R2 halt ignores cmd", 1'b0, 1'b0);
        for (int i = 1; i < D; i++) begin
            tick(0, 1, 1, 0);
            check("R10 halt recovery wait", 1'b0, 1'b0);
        end
        tick(0, 1, 1, 0);
        check("R10 halt recovery", 1'b0, 1'b1);
        // R3 fault then R10 recovery
        tick(0, 1, 1, 1);
        check("R3 fault", 1'b0, 1'b0);
        tick(1, 0, 1, 1);
        check("R3 fault ignores cmd", 1'b0, 1'b0);
        for (int i = 1; i < D; i++) begin
            tick(1, 0, 1, 0);
            check("R10 fault recovery wait", 1'b0, 1'b0);
        end
        tick(1, 0, 1, 0);
        check("R10 fault recovery", 1'b1, 1'b0);
        // Sweep of all combinations with hold lengths
        for (int c = 0; c < 16; c++) begin
            for (int hold = 1; hold <= 6; hold++) begin
                for (int k = 0; k < hold; k++) begin
                    tick(c[0], c[1], !c[2] || (c[3] && hold > 3), c[3] && c[2]);
                    check(tag_of(hi_cmd, lo_cmd, halt_n, fault_force), m_hi, m_lo);
                    checks++;
                    if (hi_gate && lo_gate) begin
                        failures++;
                        $display("FAIL R7 hi_gate=%b lo_gate=%b expected not both", hi_gate, lo_gate);
                    end
                end
            end
        end
        // Pseudo-random run
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            tick(lf[0] & lf[6], lf[1] & lf[7], !(lf[4:2] == 3'd0), lf[11:9] == 3'd0 && lf[8]);
            check(tag_of(hi_cmd, lo_cmd, halt_n, fault_force), m_hi, m_lo);
            checks++;
            if (hi_gate && lo_gate) begin
                failures++;
                $display("FAIL R7 hi_gate=%b lo_gate=%b expected not both", hi_gate, lo_gate);
            end
        end
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule